// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Handler

This block is the interrupt-servicing half of a backplane bus controller. It watches a set of active-low interrupt request lines coming from plug-in modules. Each line is synchronized and must be seen asserted on two consecutive samples before it counts. Among the qualified requests the highest-numbered level is chosen. The block then runs one acknowledge read cycle on the bus. During that cycle it drives the acknowledge daisy-chain line and a read strobe, and places the chosen level number on three address lines.

The module at the end of the chain answers in one of two ways. It may return an 8-bit status/ID word together with a data acknowledge, which the block latches into a register the host can read. Otherwise the bus timer ends the cycle with a bus error, and the block sets a sticky error flag. In both cases the served level is recorded and one host interrupt is raised. That interrupt stays asserted until software clears it through a write. While it is pending, no further acknowledge cycle is started.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, host_irq_o, ack_chain_o and ack_strobe_o are 0, and both host registers read as 0.
- R2: A request line held low for only one clock sample never starts an acknowledge cycle. A line held low for two or more consecutive samples does start one.
- R3: When several request lines are low, the cycle serves the highest-numbered one. Input bit k is level k+1, and ack_lvl_o carries that level in binary, from 1 to 7.
- R4: During an acknowledge cycle, ack_chain_o and ack_strobe_o are both 1 and ack_lvl_o is stable. They stay that way until ack_dtack_i or ack_berr_i is seen high.
- R5: On ack_dtack_i, ack_data_i is captured into the vector register (host address 0, bits 7:0). The level is written to status bits 4:2, and host_irq_o rises one cycle later.
- R6: host_irq_o stays 1 until the host writes address 1 with bit 0 set. While it is 1, no new acknowledge cycle starts, even if requests are held.
- R7: On ack_berr_i, which takes priority over ack_dtack_i, status bit 1 (error) is set and the level is recorded in bits 4:2. host_irq_o rises and the vector register keeps its old value.
- R8: The error flag stays set across a bit-0 clear. It is cleared only by writing address 1 with bit 1 set.
- R9: After the cycle ends, the strobes drop at once. A new cycle may start only once both ack_dtack_i and ack_berr_i have been seen low. Status bit 5 reads 1 while a cycle or its release phase is in progress, and bit 0 mirrors host_irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n_i | input | 7 | Request lines, active low, bit k = level k+1 |
| ack_chain_o | output | 1 | Drives the acknowledge daisy chain |
| ack_strobe_o | output | 1 | Read strobe of the acknowledge cycle |
| ack_lvl_o | output | 3 | Level being served, on address lines 3..1 |
| ack_data_i | input | 8 | Status/ID word returned by the module |
| ack_dtack_i | input | 1 | Data acknowledge from the module |
| ack_berr_i | input | 1 | Bus error from the bus timer |
| host_addr_i | input | 1 | Host register select: 0 vector, 1 status |
| host_wr_i | input | 1 | Host write strobe (status address only) |
| host_wdata_i | input | 2 | Clear bits: bit 0 interrupt, bit 1 error |
| host_rdata_o | output | 16 | Read data of the selected register |
| host_irq_o | output | 1 | Host interrupt |

## Verification
The hardest situation to reach from the ports is a pending host interrupt that has to hold back a request which is still being driven. If the bench released the request as soon as the module answered, the blocking would never be exercised. So for every one of the 127 non-empty request patterns, the bench keeps the requests low for twenty cycles after the cycle ends and watches that the strobe stays quiet. It releases them only before it writes the clear. The bus-error path is reached by answering each single level with a bus error in place of an acknowledge. A one-sample request glitch is injected straight after reset.

// File: rtl/irq_ack_pkg.sv
// Package: shared state encoding and host register layout for the
// interrupt acknowledge handler. Assumes a two-entry host register space.
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE    = 2'd0,
        ACK_RUN     = 2'd1,
        ACK_RELEASE = 2'd2
    } ack_state_e;

    localparam logic ADDR_VECTOR = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    localparam int ST_PEND    = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_LVL_LSB = 2;

    localparam int CLR_PEND = 0;
    localparam int CLR_ERR  = 1;

endpackage

// File: rtl/irq_req_sync.sv
// Request qualifier: brings each active-low request line into the clock
// domain through two flops. It reports a line as qualified only when two
// consecutive synchronized samples both show it asserted.
// Assumes the lines are level requests held until served.
module irq_req_sync #(
    parameter int NUM_LVL = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_n_i,
    output logic [NUM_LVL-1:0] qual_o
);

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
            logic meta_q;
            logic sync_q;
            logic prev_q;

            // Two-flop synchronizer plus one history flop, active-high inside.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= ~irq_n_i[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            // Qualified when the current and previous samples are both asserted.
            assign qual_o[g] = sync_q & prev_q;

            AST_QUAL_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
                qual_o[g] |-> (!$past(irq_n_i[g], 2) && !$past(irq_n_i[g], 3))); // R2
        end
    endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
// Priority picker: from the qualified request vector it selects the
// highest-numbered line. Bit k is reported as level k+1, and 0 means none.
module irq_prio_enc #(
    parameter int NUM_LVL = 7,
    localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] pend_i,
    output logic               valid_o,
    output logic [LVL_W-1:0]   lvl_o
);

    // Scan upward so the last set bit, the highest level, wins.
    always_comb begin
        valid_o = 1'b0;
        lvl_o   = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            if (pend_i[k]) begin
                valid_o = 1'b1;
                lvl_o   = LVL_W'(k + 1);
            end
        end
    end

    AST_PRIO_NONE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (((pend_i >> lvl_o) == '0) && pend_i[lvl_o - LVL_W'(1)])); // R3
    AST_PRIO_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (pend_i == '0)); // R3

endmodule

// File: rtl/irq_ack_fsm.sv
// Acknowledge cycle sequencer. It starts a read cycle when a request is
// qualified, no host interrupt is pending and the bus responses are idle.
// It drives the chain line and strobe with a latched level, and finishes on
// data acknowledge or bus error (error wins). It then waits for both
// responses to go low before returning to idle.
module irq_ack_fsm #(
    parameter int NUM_LVL = 7,
    localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [LVL_W-1:0] req_lvl_i,
    input  logic             irq_pending_i,
    input  logic             dtack_i,
    input  logic             berr_i,
    output logic             chain_o,
    output logic             strobe_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             done_ok_o,
    output logic             done_err_o,
    output logic             busy_o
);

    import irq_ack_pkg::*;

    ack_state_e       state_q;
    logic [LVL_W-1:0] lvl_q;
    logic             start;

    // A cycle may begin only on a clean bus with the host caught up.
    assign start = req_valid_i && !irq_pending_i && !dtack_i && !berr_i;

    // State and served-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            lvl_q   <= '0;
        end else begin
            case (state_q)
                ACK_IDLE: begin
                    if (start) begin
                        state_q <= ACK_RUN;
                        lvl_q   <= req_lvl_i;
                    end
                end
                ACK_RUN: begin
                    if (berr_i || dtack_i) begin
                        state_q <= ACK_RELEASE;
                    end
                end
                ACK_RELEASE: begin
                    if (!berr_i && !dtack_i) begin
                        state_q <= ACK_IDLE;
                    end
                end
                default: state_q <= ACK_IDLE;
            endcase
        end
    end

    // Bus-side outputs and completion pulses decoded from the state.
    always_comb begin
        chain_o    = (state_q == ACK_RUN);
        strobe_o   = (state_q == ACK_RUN);
        lvl_o      = lvl_q;
        done_err_o = (state_q == ACK_RUN) && berr_i;
        done_ok_o  = (state_q == ACK_RUN) && dtack_i && !berr_i;
        busy_o     = (state_q != ACK_IDLE);
    end

    AST_HOLD_UNTIL_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe_o) && !$past(dtack_i) && !$past(berr_i)) |-> (strobe_o && chain_o)); // R4
    AST_LVL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && $past(strobe_o)) |-> $stable(lvl_o)); // R4
    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (lvl_o != '0)); // R3
    AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> !$past(irq_pending_i)); // R6
    AST_START_CLEAN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> (!$past(dtack_i) && !$past(berr_i))); // R9
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok_o && done_err_o)); // R7

endmodule

// File: rtl/irq_host_regs.sv
// Host register file: the captured vector, the pending flag, the sticky
// error flag and the served level. Completion pulses set the flags and
// host writes clear them. Assumes completion and a clear of the same flag
// never collide, because completion only happens with nothing pending.
module irq_host_regs #(
    parameter int NUM_LVL = 7,
    parameter int VEC_W   = 8,
    parameter int DATA_W  = 16,
    localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_ok_i,
    input  logic              done_err_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [VEC_W-1:0]  data_i,
    input  logic              busy_i,
    input  logic              addr_i,
    input  logic              wr_i,
    input  logic [1:0]        wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              pend_o
);

    import irq_ack_pkg::*;

    logic [VEC_W-1:0] vec_q;
    logic [LVL_W-1:0] lvl_q;
    logic             pend_q;
    logic             err_q;
    logic             clr_pend;
    logic             clr_err;

    assign clr_pend = wr_i && (addr_i == ADDR_STATUS) && wdata_i[CLR_PEND];
    assign clr_err  = wr_i && (addr_i == ADDR_STATUS) && wdata_i[CLR_ERR];

    // Flag and capture registers; completion overrides a coincident clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            lvl_q  <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (clr_pend) pend_q <= 1'b0;
            if (clr_err)  err_q  <= 1'b0;
            if (done_ok_i) begin
                vec_q  <= data_i;
                lvl_q  <= lvl_i;
                pend_q <= 1'b1;
            end
            if (done_err_i) begin
                lvl_q  <= lvl_i;
                err_q  <= 1'b1;
                pend_q <= 1'b1;
            end
        end
    end

    // Read mux: the vector zero-extended, or the packed status word.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_VECTOR) begin
            rdata_o[VEC_W-1:0] = vec_q;
        end else begin
            rdata_o[ST_PEND]                  = pend_q;
            rdata_o[ST_ERR]                   = err_q;
            rdata_o[ST_LVL_LSB +: LVL_W]      = lvl_q;
            rdata_o[ST_LVL_LSB + LVL_W]       = busy_i;
        end
    end

    assign pend_o = pend_q;

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_pend) |=> pend_q); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err) |=> err_q); // R8
    AST_VEC_KEEP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done_err_i |=> $stable(vec_q)); // R7
    AST_CAPTURE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_i |=> (pend_q && (vec_q == $past(data_i)))); // R5

endmodule

// File: rtl/irq_ack_ctrl.sv
// Top of the prioritized interrupt acknowledge handler. It joins the
// request qualifier, the priority picker, the acknowledge sequencer and the
// host register file. Assumes an external bus timer produces the bus error,
// and that the bus is already owned when a cycle is driven.
module irq_ack_ctrl #(
    parameter int NUM_LVL = 7,
    parameter int VEC_W   = 8,
    parameter int DATA_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LVL-1:0]           irq_n_i,
    output logic                         ack_chain_o,
    output logic                         ack_strobe_o,
    output logic [$clog2(NUM_LVL+1)-1:0] ack_lvl_o,
    input  logic [VEC_W-1:0]             ack_data_i,
    input  logic                         ack_dtack_i,
    input  logic                         ack_berr_i,
    input  logic                         host_addr_i,
    input  logic                         host_wr_i,
    input  logic [1:0]                   host_wdata_i,
    output logic [DATA_W-1:0]            host_rdata_o,
    output logic                         host_irq_o
);

    localparam int LVL_W = $clog2(NUM_LVL + 1);

    logic [NUM_LVL-1:0] qual;
    logic               req_valid;
    logic [LVL_W-1:0]   req_lvl;
    logic               pend;
    logic               done_ok;
    logic               done_err;
    logic               busy;

    irq_req_sync #(.NUM_LVL(NUM_LVL)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n_i (irq_n_i),
        .qual_o  (qual)
    );

    irq_prio_enc #(.NUM_LVL(NUM_LVL)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (qual),
        .valid_o (req_valid),
        .lvl_o   (req_lvl)
    );

    irq_ack_fsm #(.NUM_LVL(NUM_LVL)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_lvl_i     (req_lvl),
        .irq_pending_i (pend),
        .dtack_i       (ack_dtack_i),
        .berr_i        (ack_berr_i),
        .chain_o       (ack_chain_o),
        .strobe_o      (ack_strobe_o),
        .lvl_o         (ack_lvl_o),
        .done_ok_o     (done_ok),
        .done_err_o    (done_err),
        .busy_o        (busy)
    );

    irq_host_regs #(
        .NUM_LVL (NUM_LVL),
        .VEC_W   (VEC_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_ok_i  (done_ok),
        .done_err_i (done_err),
        .lvl_i      (ack_lvl_o),
        .data_i     (ack_data_i),
        .busy_i     (busy),
        .addr_i     (host_addr_i),
        .wr_i       (host_wr_i),
        .wdata_i    (host_wdata_i),
        .rdata_o    (host_rdata_o),
        .pend_o     (pend)
    );

    assign host_irq_o = pend;

    AST_IRQ_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq_o) |-> ($past(ack_strobe_o) && ($past(ack_dtack_i) || $past(ack_berr_i)))); // R5

endmodule

// File: tb/sim_irq_ack_ctrl.sv
// Bench: sweeps every non-empty request pattern with a data-acknowledge
// answer, and every single level with a bus-error answer. It also injects a
// one-sample glitch. Expected values are computed arithmetically here.
module sim_irq_ack_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  irq_n_i = 7'h7F;
    logic        ack_chain_o;
    logic        ack_strobe_o;
    logic [2:0]  ack_lvl_o;
    logic [7:0]  ack_data_i = 8'h00;
    logic        ack_dtack_i = 1'b0;
    logic        ack_berr_i = 1'b0;
    logic        host_addr_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic [1:0]  host_wdata_i = 2'b00;
    logic [15:0] host_rdata_o;
    logic        host_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] last_vec = 8'h00;

    always #5 clk = ~clk;

    irq_ack_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_n_i      (irq_n_i),
        .ack_chain_o  (ack_chain_o),
        .ack_strobe_o (ack_strobe_o),
        .ack_lvl_o    (ack_lvl_o),
        .ack_data_i   (ack_data_i),
        .ack_dtack_i  (ack_dtack_i),
        .ack_berr_i   (ack_berr_i),
        .host_addr_i  (host_addr_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .host_irq_o   (host_irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        host_addr_i = a;
        #1;
        v = host_rdata_o;
    endtask

    task automatic clr(input logic [1:0] bits);
        @(negedge clk);
        host_addr_i  = 1'b1;
        host_wr_i    = 1'b1;
        host_wdata_i = bits;
        @(negedge clk);
        host_wr_i    = 1'b0;
        host_wdata_i = 2'b00;
    endtask

    function automatic int top_lvl(input logic [6:0] m);
        int e = 0;
        for (int k = 0; k < 7; k++) if (m[k]) e = k + 1;
        return e;
    endfunction

    // Serve one request pattern; use_err answers with a bus error.
    task automatic serve(input logic [6:0] mask, input bit use_err);
        int exp_lvl;
        bit seen;
        bit quiet;
        logic [7:0] vec;
        logic [15:0] v;
        exp_lvl = top_lvl(mask);
        vec = 8'((int'(mask) * 37 + 11) & 255);
        @(negedge clk);
        irq_n_i = ~mask;
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (ack_strobe_o) seen = 1'b1;
        end
        chk(seen, "R2 cycle started", int'(seen), 1);
        chk(int'(ack_lvl_o) == exp_lvl, "R3 level", int'(ack_lvl_o), exp_lvl);
        chk(ack_chain_o == 1'b1, "R4 chain", int'(ack_chain_o), 1);
        repeat (2) @(negedge clk);
        chk(ack_strobe_o && ack_chain_o && int'(ack_lvl_o) == exp_lvl,
            "R4 held", int'(ack_strobe_o), 1);
        if (use_err) begin
            ack_berr_i  = 1'b1;
            ack_dtack_i = mask[0];
        end else begin
            ack_dtack_i = 1'b1;
        end
        ack_data_i = vec;
        @(negedge clk);
        chk(host_irq_o == 1'b1, use_err ? "R7 irq" : "R5 irq", int'(host_irq_o), 1);
        chk(ack_strobe_o == 1'b0, "R9 strobe drop", int'(ack_strobe_o), 0);
        repeat (2) @(negedge clk);
        rd(1'b1, v);
        chk(ack_strobe_o == 1'b0 && v[5] == 1'b1, "R9 release busy", int'(v[5]), 1);
        ack_dtack_i = 1'b0;
        ack_berr_i  = 1'b0;
        ack_data_i  = 8'h00;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack_strobe_o || ack_chain_o) quiet = 1'b0;
        end
        chk(quiet, "R6 blocked while pending", int'(quiet), 1);
        irq_n_i = 7'h7F;
        repeat (6) @(negedge clk);
        if (!use_err) last_vec = vec;
        rd(1'b0, v);
        chk(v == {8'h00, last_vec}, use_err ? "R7 vector kept" : "R5 vector",
            int'(v), int'(last_vec));
        rd(1'b1, v);
        chk(v == 16'(1 | (int'(use_err) << 1) | (exp_lvl << 2)),
            use_err ? "R7 status" : "R5 status",
            int'(v), 1 | (int'(use_err) << 1) | (exp_lvl << 2));
        clr(2'b01);
        chk(host_irq_o == 1'b0, "R6 clear", int'(host_irq_o), 0);
        rd(1'b1, v);
        chk(v == 16'((int'(use_err) << 1) | (exp_lvl << 2)), "R8 after bit0 clear",
            int'(v), (int'(use_err) << 1) | (exp_lvl << 2));
        if (use_err) begin
            clr(2'b10);
            rd(1'b1, v);
            chk(v == 16'(exp_lvl << 2), "R8 error cleared", int'(v), exp_lvl << 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!host_irq_o && !ack_chain_o && !ack_strobe_o, "R1 outputs",
            int'({host_irq_o, ack_chain_o, ack_strobe_o}), 0);
        rd(1'b0, v);
        chk(v == 16'h0000, "R1 vector", int'(v), 0);
        rd(1'b1, v);
        chk(v == 16'h0000, "R1 status", int'(v), 0);
        // R2: one-sample glitch on level 7 is ignored
        @(negedge clk);
        irq_n_i[6] = 1'b0;
        @(negedge clk);
        irq_n_i = 7'h7F;
        quiet = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ack_strobe_o || host_irq_o) quiet = 1'b0;
        end
        chk(quiet, "R2 glitch ignored", int'(quiet), 1);
        // R3 R5 R6 R9: every non-empty pattern with acknowledge
        for (int m = 1; m < 128; m++) serve(7'(m), 1'b0);
        // R7 R8: every single level ending in bus error
        for (int l = 0; l < 7; l++) serve(7'(1 << l), 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule